// File: doc/BRIEF.md
# Microprogram sequencer with control store

This block is the control half of a microprogrammed processor. It holds a constant table of control words and steps through it. Each word carries the control signals for one step of a control sequence, plus sequencing fields. After each word executes, the sequencer picks the next address from one of four sources:

- the next address in order;
- a taken micro-branch;
- the starting address of a routine, looked up from a newly loaded opcode;
- the first word of the fetch routine, when the word carries an end marker.

The datapath that consumes the control signals is outside this block.

The word at the next sequential address is always read while the current word executes. A straight run of words therefore executes one per cycle. When any redirect happens, the speculatively read word is thrown away and one idle cycle is inserted. No stale control signals reach the datapath during that cycle.

Each control word is packed as follows, from least to most significant bit:

| Field | Width | Meaning |
|---|---|---|
| control signals | CTRL_W | driven to the datapath |
| branch-condition selector | $clog2(N_COND+2) | picks the branch condition |
| branch target | ADDR_W | micro-branch destination |
| mode-OR enable | 1 | allows the mode flag into the target's lowest bit |
| end flag | 1 | marks the last word of a routine |

Top module: `useq_top`

## Requirements
- R1: While `rst_n` is low, `uvalid` and `ctrl_out` are 0. The first word executed after reset is at `FETCH_ADDR`.
- R2: When `uvalid` is 1, `ctrl_out` equals bits [CTRL_W-1:0] of the word at `uaddr`. When `uvalid` is 0, `ctrl_out` is 0.
- R3: A word that causes no redirect is followed in the next cycle, with no idle cycle, by the word at `uaddr`+1, modulo 2**ADDR_W.
- R4: When `ir_load` is 1 during a word without the end flag, the next cycle is idle. The cycle after that executes the word at the address held in opcode-map entry `opcode`. Entry k occupies bits [k*ADDR_W +: ADDR_W] of `MAP_INIT`.
- R5: The branch-condition selector works as follows: 0 is never taken, 1 is always taken, and 2+i is taken when `cond_in[i]` is 1. A taken branch gives one idle cycle, then the word at the target. An untaken branch continues in order.
- R6: On a taken branch whose mode-OR bit is 1 while `mode_flag` is 1, the target's least significant bit is forced to 1. Otherwise the target is used as stored.
- R7: A word with the end flag gives one idle cycle, then the word at `FETCH_ADDR`.
- R8: Redirect priority is end flag, then `ir_load`, then taken branch.
- R9: An idle cycle lasts exactly one cycle. During an idle cycle, `ir_load`, `opcode`, `cond_in` and `mode_flag` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| ir_load | input | 1 | a new instruction opcode is present this cycle |
| opcode | input | OPC_W | opcode of the loaded instruction |
| cond_in | input | N_COND | branch condition inputs |
| mode_flag | input | 1 | addressing-mode flag ORed into the branch target |
| ctrl_out | output | CTRL_W | control signals of the executing word |
| uaddr | output | ADDR_W | address of the executing word |
| uvalid | output | 1 | a word is executing (0 during idle cycles) |

## Verification
The assertions assume that every input is a plain level sampled at the rising edge, and that `ir_load` may appear in any cycle. The assertions need nothing more about the inputs, since the block ignores inputs during idle cycles. The stimulus is driven half a cycle away from the edge with random `ir_load`, `opcode`, `cond_in` and `mode_flag`. It therefore keeps within that assumption while reaching end words, always-taken branches and idle cycles that coincide with `ir_load`. A test program in the control store gives every condition selector and both mode-OR settings their own routine.

// File: rtl/useq_pkg.sv
package useq_pkg;
   // Source of the next micro address, lowest to highest priority
   typedef enum logic [1:0] {
      SRC_INC = 2'd0,
      SRC_BR  = 2'd1,
      SRC_MAP = 2'd2,
      SRC_END = 2'd3
   } nxt_src_e;
endpackage

// File: rtl/useq_store.sv
module useq_store #(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned WORD_W = 18,
   parameter logic [(2**ADDR_W)*WORD_W-1:0] TABLE = '0
) (
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [WORD_W-1:0] rd_word
);
   localparam int unsigned DEPTH = 2**ADDR_W;

   logic [WORD_W-1:0] rom [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_rom
      assign rom[g] = TABLE[g*WORD_W +: WORD_W];
   end

   assign rd_word = rom[rd_addr];
endmodule

// File: rtl/useq_map.sv
module useq_map #(
   parameter int unsigned OPC_W  = 4,
   parameter int unsigned ADDR_W = 6,
   parameter logic [(2**OPC_W)*ADDR_W-1:0] TABLE = '0
) (
   input  logic [OPC_W-1:0]  opcode,
   output logic [ADDR_W-1:0] start_addr
);
   localparam int unsigned N_OPC = 2**OPC_W;

   logic [ADDR_W-1:0] entry [N_OPC];

   for (genvar g = 0; g < N_OPC; g++) begin : g_ent
      assign entry[g] = TABLE[g*ADDR_W +: ADDR_W];
   end

   assign start_addr = entry[opcode];
endmodule

// File: rtl/useq_next.sv
module useq_next
   import useq_pkg::*;
#(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned N_COND = 2,
   parameter int unsigned CSEL_W = 2
) (
   input  logic              ex_valid,
   input  logic              end_f,
   input  logic              ir_load,
   input  logic [CSEL_W-1:0] csel,
   input  logic [ADDR_W-1:0] target,
   input  logic              modor,
   input  logic [N_COND-1:0] cond_in,
   input  logic              mode_flag,
   output nxt_src_e          src,
   output logic [ADDR_W-1:0] br_addr
);
   localparam int unsigned CSEL_N = 2**CSEL_W;

   logic [CSEL_N-1:0] cond_vec;
   logic              taken;

   for (genvar i = 0; i < CSEL_N; i++) begin : g_cv
      if (i == 0) begin : g_never
         assign cond_vec[i] = 1'b0;
      end else if (i == 1) begin : g_always
         assign cond_vec[i] = 1'b1;
      end else if (i - 2 < N_COND) begin : g_in
         assign cond_vec[i] = cond_in[i-2];
      end else begin : g_pad
         assign cond_vec[i] = 1'b0;
      end
   end

   assign taken = cond_vec[csel];

   if (ADDR_W > 1) begin : g_or_wide
      assign br_addr = {target[ADDR_W-1:1], target[0] | (modor & mode_flag)};
   end else begin : g_or_narrow
      assign br_addr = target | (modor & mode_flag);
   end

   always_comb begin
      src = SRC_INC;
      if (ex_valid) begin
         if (end_f)        src = SRC_END;
         else if (ir_load) src = SRC_MAP;
         else if (taken)   src = SRC_BR;
      end
   end
endmodule

// File: rtl/useq_top.sv
module useq_top
   import useq_pkg::*;
#(
   parameter int unsigned CTRL_W = 8,
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned OPC_W  = 4,
   parameter int unsigned N_COND = 2,
   parameter logic [ADDR_W-1:0] FETCH_ADDR = '0,
   localparam int unsigned CSEL_W = $clog2(N_COND + 2),
   localparam int unsigned WORD_W = CTRL_W + CSEL_W + ADDR_W + 2,
   parameter logic [(2**ADDR_W)*WORD_W-1:0] STORE_INIT = '0,
   parameter logic [(2**OPC_W)*ADDR_W-1:0]  MAP_INIT   = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ir_load,
   input  logic [OPC_W-1:0]  opcode,
   input  logic [N_COND-1:0] cond_in,
   input  logic              mode_flag,
   output logic [CTRL_W-1:0] ctrl_out,
   output logic [ADDR_W-1:0] uaddr,
   output logic              uvalid
);
   localparam int unsigned CSEL_LSB = CTRL_W;
   localparam int unsigned TGT_LSB  = CTRL_W + CSEL_W;
   localparam int unsigned MOR_BIT  = WORD_W - 2;
   localparam int unsigned END_BIT  = WORD_W - 1;

   if (ADDR_W < 2 || ADDR_W > 10) begin : g_bad_addr
      $error("useq_top: ADDR_W must lie in 2..10");
   end
   if (OPC_W < 1 || OPC_W > 8) begin : g_bad_opc
      $error("useq_top: OPC_W must lie in 1..8");
   end
   if (N_COND < 1) begin : g_bad_cond
      $error("useq_top: N_COND must be at least 1");
   end
   if (CTRL_W < 1) begin : g_bad_ctrl
      $error("useq_top: CTRL_W must be at least 1");
   end

   logic [ADDR_W-1:0] fa;        // address being prefetched
   logic [WORD_W-1:0] ex_word;   // word executing now
   logic [ADDR_W-1:0] ex_addr;
   logic              ex_valid;

   logic [WORD_W-1:0] rd_word;
   logic [ADDR_W-1:0] map_addr;
   logic [ADDR_W-1:0] br_addr;
   logic [ADDR_W-1:0] red_addr;
   nxt_src_e          src;
   logic              redirect;
   logic              ex_end;

   useq_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .TABLE(STORE_INIT)) u_store (
      .rd_addr (fa),
      .rd_word (rd_word)
   );

   useq_map #(.OPC_W(OPC_W), .ADDR_W(ADDR_W), .TABLE(MAP_INIT)) u_map (
      .opcode     (opcode),
      .start_addr (map_addr)
   );

   assign ex_end = ex_word[END_BIT];

   useq_next #(.ADDR_W(ADDR_W), .N_COND(N_COND), .CSEL_W(CSEL_W)) u_next (
      .ex_valid  (ex_valid),
      .end_f     (ex_end),
      .ir_load   (ir_load),
      .csel      (ex_word[CSEL_LSB +: CSEL_W]),
      .target    (ex_word[TGT_LSB +: ADDR_W]),
      .modor     (ex_word[MOR_BIT]),
      .cond_in   (cond_in),
      .mode_flag (mode_flag),
      .src       (src),
      .br_addr   (br_addr)
   );

   always_comb begin
      unique case (src)
         SRC_END: red_addr = FETCH_ADDR;
         SRC_MAP: red_addr = map_addr;
         SRC_BR:  red_addr = br_addr;
         default: red_addr = fa;
      endcase
   end

   assign redirect = (src != SRC_INC);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fa       <= FETCH_ADDR;
         ex_word  <= '0;
         ex_addr  <= '0;
         ex_valid <= 1'b0;
      end else if (redirect) begin
         // drop the speculatively read word, restart at the new address
         fa       <= red_addr;
         ex_word  <= '0;
         ex_valid <= 1'b0;
      end else begin
         ex_word  <= rd_word;
         ex_addr  <= fa;
         ex_valid <= 1'b1;
         fa       <= fa + 1'b1;
      end
   end

   assign ctrl_out = ex_valid ? ex_word[CTRL_W-1:0] : '0;
   assign uaddr    = ex_addr;
   assign uvalid   = ex_valid;
endmodule

// File: rtl/useq_chk.sv
module useq_chk #(
   parameter int unsigned CTRL_W = 8,
   parameter int unsigned ADDR_W = 6,
   parameter logic [ADDR_W-1:0] FETCH_ADDR = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ir_load,
   input logic [CTRL_W-1:0] ctrl_out,
   input logic [ADDR_W-1:0] uaddr,
   input logic              uvalid,
   input logic              end_f,
   input logic              redirect
);
   // R1
   always @(negedge clk) begin
      if (!rst_n) begin
         reset_idle_chk: assert (!uvalid && ctrl_out == '0);
      end
   end

   // R2
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !uvalid |-> ctrl_out == '0);

   // R3
   seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (uvalid && !redirect) |=> (uvalid && uaddr == ADDR_W'($past(uaddr) + 1'b1)));

   // R4
   load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (uvalid && ir_load) |=> !uvalid);

   // R7
   end_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (uvalid && end_f) |=> !uvalid ##1 (uvalid && uaddr == FETCH_ADDR));

   // R9
   one_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !uvalid |=> uvalid);
endmodule

bind useq_top useq_chk #(
   .CTRL_W     (CTRL_W),
   .ADDR_W     (ADDR_W),
   .FETCH_ADDR (FETCH_ADDR)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ir_load  (ir_load),
   .ctrl_out (ctrl_out),
   .uaddr    (uaddr),
   .uvalid   (uvalid),
   .end_f    (ex_end),
   .redirect (redirect)
);

// File: tb/tb_useq_top.sv
`timescale 1ns/1ps
module tb_useq_top;
   localparam int CW   = 8;
   localparam int AW   = 6;
   localparam int OW   = 4;
   localparam int NC   = 2;
   localparam int WW   = 18;   // 8 ctrl + 2 csel + 6 target + modor + end
   localparam int NW   = 64;
   localparam int FETCH = 0;

   // ---- test program, described field by field ----
   function automatic int f_ctrl(input int a);
      return (a * 37 + 11) & 255;
   endfunction
   function automatic bit in_rt(input int a);
      return a >= 8 && a < 56;
   endfunction
   function automatic int f_cs(input int a);
      if (a == 3) return 1;
      if (in_rt(a) && (a - 8) % 3 == 1) return ((a - 8) / 3) % 4;
      return 0;
   endfunction
   function automatic int f_tgt(input int a);
      if (in_rt(a) && (a - 8) % 3 == 1) return 56 + 2 * (((a - 8) / 3) % 4);
      return 0;
   endfunction
   function automatic int f_mor(input int a);
      if (in_rt(a) && (a - 8) % 3 == 1) return ((a - 8) / 3) % 2;
      return 0;
   endfunction
   function automatic int f_end(input int a);
      if (a >= 56) return 1;
      if (in_rt(a) && (a - 8) % 3 == 2) return 1;
      return 0;
   endfunction
   function automatic int f_map(input int k);
      return 8 + 3 * k;
   endfunction

   function automatic logic [NW*WW-1:0] build_store();
      logic [NW*WW-1:0] v;
      v = '0;
      for (int a = 0; a < NW; a++) begin
         v[a*WW +: WW] = {1'(f_end(a)), 1'(f_mor(a)), 6'(f_tgt(a)), 2'(f_cs(a)), 8'(f_ctrl(a))};
      end
      return v;
   endfunction
   function automatic logic [16*AW-1:0] build_map();
      logic [16*AW-1:0] v;
      v = '0;
      for (int k = 0; k < 16; k++) v[k*AW +: AW] = 6'(f_map(k));
      return v;
   endfunction

   localparam logic [NW*WW-1:0] STORE_P = build_store();
   localparam logic [16*AW-1:0] MAP_P   = build_map();

   logic          clk = 1'b0;
   logic          rst_n = 1'b1;
   logic          ir_load = 1'b0;
   logic [OW-1:0] opcode = '0;
   logic [NC-1:0] cond_in = '0;
   logic          mode_flag = 1'b0;
   logic [CW-1:0] ctrl_out;
   logic [AW-1:0] uaddr;
   logic          uvalid;

   useq_top #(
      .CTRL_W(CW), .ADDR_W(AW), .OPC_W(OW), .N_COND(NC),
      .FETCH_ADDR(6'(FETCH)), .STORE_INIT(STORE_P), .MAP_INIT(MAP_P)
   ) dut (
      .clk(clk), .rst_n(rst_n), .ir_load(ir_load), .opcode(opcode),
      .cond_in(cond_in), .mode_flag(mode_flag),
      .ctrl_out(ctrl_out), .uaddr(uaddr), .uvalid(uvalid)
   );

   always #2 clk = ~clk;   // 250 MHz

   int n_chk  = 0;
   int n_fail = 0;

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // reference model state
   int    m_valid = 0;
   int    m_addr  = 0;
   int    m_nxt   = FETCH;
   string tag     = "R1";

   initial begin
      #1 rst_n = 1'b0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check("R1", int'(uvalid), 0);
         check("R1", int'(ctrl_out), 0);
      end
      rst_n = 1'b1;
      m_valid = 1; m_addr = FETCH; m_nxt = FETCH + 1; tag = "R1";

      for (int cyc = 0; cyc < 4000; cyc++) begin
         @(negedge clk);
         check(tag, int'(uvalid), m_valid);
         if (m_valid != 0) check(tag, int'(uaddr), m_addr);
         check("R2", int'(ctrl_out), (m_valid != 0) ? f_ctrl(m_addr) : 0);

         // new inputs for the coming edge
         ir_load   = ($urandom % 3) == 0;
         opcode    = OW'($urandom);
         cond_in   = NC'($urandom);
         mode_flag = 1'($urandom);

         if (m_valid != 0) begin
            int  cs;
            bit  tk;
            int  tg;
            cs = f_cs(m_addr);
            tk = (cs == 1) || (cs == 2 && cond_in[0]) || (cs == 3 && cond_in[1]);
            if (f_end(m_addr) != 0) begin
               tg = FETCH; tag = ir_load ? "R8" : "R7";
            end else if (ir_load) begin
               tg = f_map(int'(opcode)); tag = tk ? "R8" : "R4";
            end else if (tk) begin
               tg = f_tgt(m_addr);
               if (f_mor(m_addr) != 0 && mode_flag) tg = tg | 1;
               tag = (f_mor(m_addr) != 0) ? "R6" : "R5";
            end else begin
               tg = -1; tag = "R3";
            end
            if (tg >= 0) begin
               m_valid = 0; m_nxt = tg;
            end else begin
               m_addr = m_nxt; m_nxt = (m_nxt + 1) % NW;
            end
         end else begin
            if (ir_load || mode_flag) tag = "R9";
            m_valid = 1; m_addr = m_nxt; m_nxt = (m_nxt + 1) % NW;
         end
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(4 * 100000);
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end
endmodule